// File: doc/BRIEF.md
# Host Wake-Access Power Handshake

This block holds the device-side power state behind a single 32-bit host control register. The host uses two writable bits. An initialise bit brings the device into full-power operation, and a wake-hold bit keeps the device awake for as long as it stays set. The block reports whether the internal clock domain is up, whether it is on its way down, which power-save mode is in force, and the level of an external radio-kill switch.

Internal firmware can ask to power down. When the host is not holding the device awake, the block raises a going-to-sleep flag for a fixed number of cycles and then drops clock ready. Coming up again takes a fixed wake-up delay. The block starts that delay only once wake is required, which means the device is initialised and the host either holds the device awake or firmware has no sleep request pending. A registered access-granted output tells the rest of the chip when host access to internal resources is allowed. A one-cycle soft-reset pulse returns everything to the low-power state.

Top module: `hwake_ctrl`

## Requirements
- R1: After rst_n is released, the register reads 32'h0100_0000: clock ready (bit 0), init done (bit 2), wake hold (bit 3), going to sleep (bit 4) and radio kill (bit 27) are 0, and the power-save field (bits 26:24) is 001. clk_ready and access_ok are 0.
- R2: A register write changes only bit 2 (init done) and bit 3 (wake hold). Every other bit of the write data has no effect on the value read back.
- R3: Clock ready stays 0 while init done is 0, whatever the value of the wake-hold bit. A write that clears init done drops clock ready and access_ok one cycle after the write cycle.
- R4: When a write sets init done and either wake hold is set or fw_sleep_req is low, clock ready (bit 0 and the clk_ready pin) rises exactly WAKE_CYCLES+1 clock cycles after the write cycle.
- R5: While the device is awake and wake hold is clear, a high fw_sleep_req sets going to sleep (bit 4) for exactly SLEEP_CYCLES cycles, starting the cycle after the request is sampled. Clock ready then falls and the power-save field reads 001.
- R6: While wake hold is set, fw_sleep_req has no effect. Setting wake hold while going to sleep is 1 cancels the sleep entry: the next cycle shows bit 4 at 0 and clock ready at 1.
- R7: access_ok is a registered output. It equals clock ready AND NOT going to sleep in every cycle.
- R8: A soft_rst pulse clears init done, wake hold and clock ready and sets the power-save field to 001 in the next cycle. It takes priority over a register write in the same cycle.
- R9: The power-save field reads 000 while clock ready is 1 and radio kill is 0. It reads 010 while clock ready is 1 and radio kill is 1. It reads 001 while clock ready is 0.
- R10: Bit 27 follows rf_kill_in after RFK_SYNC_STAGES clock cycles of synchronisation.
- R11: A sleeping device that is still initialised wakes again WAKE_CYCLES+1 cycles after fw_sleep_req falls. Clearing init done while the wake-up delay is counting aborts it, and clock ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | One-cycle soft-reset pulse |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 32 | Write data; only bits 2 and 3 are used |
| reg_rdata | output | 32 | Current control/status register value |
| fw_sleep_req | input | 1 | Firmware request to enter power-save |
| rf_kill_in | input | 1 | Asynchronous radio-kill switch level |
| clk_ready | output | 1 | Internal clock domain is powered and running |
| access_ok | output | 1 | Host access to internal resources is allowed |

## Verification
The hardest state to reach from the ports is a sleep entry that is already underway when the host asserts wake hold. The going-to-sleep window is only SLEEP_CYCLES long, and the register write adds its own cycle of latency. To get there, the stimulus first brings the device awake with wake hold clear, then raises fw_sleep_req, and issues the wake-hold write on the cycle right after going to sleep appears. The cancel therefore lands inside the window, ahead of the timer's expiry. The same directed approach also reaches an abort of the wake-up delay by clearing init done partway through the count.

// File: rtl/hwake_pkg.sv
`timescale 1ns/1ps
package hwake_pkg;

   // Register bit positions decoded by the host driver.
   localparam int unsigned BIT_CLK_RDY  = 0;
   localparam int unsigned BIT_INIT     = 2;
   localparam int unsigned BIT_WAKE     = 3;
   localparam int unsigned BIT_GTS      = 4;
   localparam int unsigned MODE_LSB     = 24;
   localparam int unsigned MODE_W       = 3;
   localparam int unsigned BIT_RFKILL   = 27;
   localparam int unsigned REG_W        = 32;

   typedef enum logic [1:0] {
      ST_ASLEEP   = 2'd0,
      ST_WAKING   = 2'd1,
      ST_AWAKE    = 2'd2,
      ST_SLEEPING = 2'd3
   } pwr_state_e;

   typedef enum logic [2:0] {
      PM_NONE       = 3'b000,
      PM_MAC_DOWN   = 3'b001,
      PM_RADIO_DOWN = 3'b010,
      PM_FAULT      = 3'b011
   } pwr_mode_e;

endpackage

// File: rtl/hwake_sync.sv
`timescale 1ns/1ps
module hwake_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b0;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= {q[STAGES-2:0], din};
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/hwake_timer.sv
`timescale 1ns/1ps
module hwake_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // Final cycle of the loaded window.
   assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/hwake_fsm.sv
`timescale 1ns/1ps
module hwake_fsm
   import hwake_pkg::*;
#(
   parameter int unsigned WAKE_CYCLES  = 8,
   parameter int unsigned SLEEP_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       init_done,
   input  logic       wake_hold,
   input  logic       fw_sleep_req,
   input  logic       rf_kill,
   output logic       clk_ready,
   output logic       going_sleep,
   output logic       access_ok,
   output logic [2:0] pwr_mode
);

   localparam int unsigned MAX_CYC = (WAKE_CYCLES > SLEEP_CYCLES) ? WAKE_CYCLES : SLEEP_CYCLES;
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] WAKE_LD  = CNT_W'(WAKE_CYCLES);
   localparam logic [CNT_W-1:0] SLEEP_LD = CNT_W'(SLEEP_CYCLES);

   pwr_state_e       st_q, st_nxt;
   logic             tmr_load, tmr_done, wake_need, acc_q;
   logic [CNT_W-1:0] tmr_val;

   hwake_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   assign wake_need = init_done & (wake_hold | ~fw_sleep_req);

   always_comb begin
      st_nxt   = st_q;
      tmr_load = 1'b0;
      tmr_val  = WAKE_LD;
      if (soft_rst) begin
         st_nxt = ST_ASLEEP;
      end else begin
         unique case (st_q)
            ST_ASLEEP: begin
               if (wake_need) begin
                  st_nxt   = ST_WAKING;
                  tmr_load = 1'b1;
                  tmr_val  = WAKE_LD;
               end
            end
            ST_WAKING: begin
               if (!init_done)    st_nxt = ST_ASLEEP;
               else if (tmr_done) st_nxt = ST_AWAKE;
            end
            ST_AWAKE: begin
               if (!init_done) begin
                  st_nxt = ST_ASLEEP;
               end else if (fw_sleep_req && !wake_hold) begin
                  st_nxt   = ST_SLEEPING;
                  tmr_load = 1'b1;
                  tmr_val  = SLEEP_LD;
               end
            end
            ST_SLEEPING: begin
               if (!init_done)    st_nxt = ST_ASLEEP;
               else if (wake_hold) st_nxt = ST_AWAKE;
               else if (tmr_done) st_nxt = ST_ASLEEP;
            end
            default: st_nxt = ST_ASLEEP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_ASLEEP;
         acc_q <= 1'b0;
      end else begin
         st_q  <= st_nxt;
         acc_q <= (st_nxt == ST_AWAKE);
      end
   end

   assign clk_ready   = (st_q == ST_AWAKE) || (st_q == ST_SLEEPING);
   assign going_sleep = (st_q == ST_SLEEPING);
   assign access_ok   = acc_q;

   always_comb begin
      if (!clk_ready)   pwr_mode = PM_MAC_DOWN;
      else if (rf_kill) pwr_mode = PM_RADIO_DOWN;
      else              pwr_mode = PM_NONE;
   end

endmodule

// File: rtl/hwake_host_reg.sv
`timescale 1ns/1ps
module hwake_host_reg
   import hwake_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_en,
   input  logic             wr_init,
   input  logic             wr_wake,
   input  logic             clk_ready,
   input  logic             going_sleep,
   input  logic [2:0]       pwr_mode,
   input  logic             rf_kill,
   output logic             init_done,
   output logic             wake_hold,
   output logic [REG_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_done <= 1'b0;
         wake_hold <= 1'b0;
      end else if (soft_rst) begin
         init_done <= 1'b0;
         wake_hold <= 1'b0;
      end else if (wr_en) begin
         init_done <= wr_init;
         wake_hold <= wr_wake;
      end
   end

   always_comb begin
      rdata                       = '0;
      rdata[BIT_CLK_RDY]          = clk_ready;
      rdata[BIT_INIT]             = init_done;
      rdata[BIT_WAKE]             = wake_hold;
      rdata[BIT_GTS]              = going_sleep;
      rdata[MODE_LSB +: MODE_W]   = pwr_mode;
      rdata[BIT_RFKILL]           = rf_kill;
   end

endmodule

// File: rtl/hwake_ctrl.sv
`timescale 1ns/1ps
module hwake_ctrl
   import hwake_pkg::*;
#(
   parameter int unsigned WAKE_CYCLES     = 8,
   parameter int unsigned SLEEP_CYCLES    = 4,
   parameter int unsigned RFK_SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        fw_sleep_req,
   input  logic        rf_kill_in,
   output logic        clk_ready,
   output logic        access_ok
);

   generate
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("hwake_ctrl: WAKE_CYCLES must be at least 1");
      end
      if (SLEEP_CYCLES < 1) begin : g_bad_sleep
         $error("hwake_ctrl: SLEEP_CYCLES must be at least 1");
      end
      if (RFK_SYNC_STAGES > 4) begin : g_bad_sync
         $error("hwake_ctrl: RFK_SYNC_STAGES must be 4 or less");
      end
   endgenerate

   logic       rfk_s, init_done, wake_hold, going_sleep;
   logic [2:0] pwr_mode;
   logic       unused_wdata_bits;

   assign unused_wdata_bits = ^{reg_wdata[31:BIT_WAKE+1], reg_wdata[BIT_INIT-1:0]};

   hwake_sync #(.STAGES(RFK_SYNC_STAGES)) u_rfk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rf_kill_in),
      .dout  (rfk_s)
   );

   hwake_host_reg u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .wr_en       (reg_wr_en),
      .wr_init     (reg_wdata[BIT_INIT]),
      .wr_wake     (reg_wdata[BIT_WAKE]),
      .clk_ready   (clk_ready),
      .going_sleep (going_sleep),
      .pwr_mode    (pwr_mode),
      .rf_kill     (rfk_s),
      .init_done   (init_done),
      .wake_hold   (wake_hold),
      .rdata       (reg_rdata)
   );

   hwake_fsm #(
      .WAKE_CYCLES  (WAKE_CYCLES),
      .SLEEP_CYCLES (SLEEP_CYCLES)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .init_done    (init_done),
      .wake_hold    (wake_hold),
      .fw_sleep_req (fw_sleep_req),
      .rf_kill      (rfk_s),
      .clk_ready    (clk_ready),
      .going_sleep  (going_sleep),
      .access_ok    (access_ok),
      .pwr_mode     (pwr_mode)
   );

endmodule

// File: rtl/hwake_ctrl_chk.sv
`timescale 1ns/1ps
module hwake_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        soft_rst,
   input logic [31:0] reg_rdata,
   input logic        clk_ready,
   input logic        access_ok
);

   assert_access_rule_R7: assert property (@(posedge clk) disable iff (!rst_n)
      access_ok == (clk_ready && !reg_rdata[4]));

   assert_ready_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[0] == clk_ready);

   assert_no_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[2] |=> !clk_ready);

   assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!clk_ready && reg_rdata[3:2] == 2'b00 && reg_rdata[26:24] == 3'b001));

   assert_gts_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[4] |-> clk_ready);

   assert_mode_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ready |-> reg_rdata[26:24] == 3'b001);

   assert_mode_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready |-> (reg_rdata[26] == 1'b0 && reg_rdata[24] == 1'b0 && reg_rdata[25] == reg_rdata[27]));

   assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[4] && reg_rdata[3] && reg_rdata[2] && !soft_rst) |=> (clk_ready && !reg_rdata[4]));

endmodule

bind hwake_ctrl hwake_ctrl_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .reg_rdata (reg_rdata),
   .clk_ready (clk_ready),
   .access_ok (access_ok)
);

// File: tb/hwake_ctrl_tb.sv
`timescale 1ns/1ps
module hwake_ctrl_tb_top;

   localparam int unsigned WAKE  = 8;
   localparam int unsigned SLEEP = 4;
   localparam int unsigned SYNC  = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fw_sleep_req = 1'b0;
   logic        rf_kill_in = 1'b0;
   logic        clk_ready;
   logic        access_ok;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   hwake_ctrl #(
      .WAKE_CYCLES     (WAKE),
      .SLEEP_CYCLES    (SLEEP),
      .RFK_SYNC_STAGES (SYNC)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (soft_rst),
      .reg_wr_en    (reg_wr_en),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .fw_sleep_req (fw_sleep_req),
      .rf_kill_in   (rf_kill_in),
      .clk_ready    (clk_ready),
      .access_ok    (access_ok)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr_en = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic t_reset();
      chk("R1 rdata", reg_rdata, 32'h0100_0000);
      chk("R1 clk_ready", {31'b0, clk_ready}, 32'd0);
      chk("R1 access_ok", {31'b0, access_ok}, 32'd0);
   endtask

   task automatic t_write_mask();
      wr(32'hF7FF_FFF3);
      chk("R2 masked write", reg_rdata, 32'h0100_0000);
      wr(32'h0000_0008);
      repeat (WAKE + 4) tick();
      chk("R3 wake hold without init", reg_rdata, 32'h0100_0008);
      chk("R3 clk_ready pin", {31'b0, clk_ready}, 32'd0);
   endtask

   task automatic t_wake();
      wr(32'h0000_000C);
      repeat (WAKE) tick();
      chk("R4 not ready before delay", {31'b0, clk_ready}, 32'd0);
      tick();
      chk("R4 ready after delay", {31'b0, clk_ready}, 32'd1);
      chk("R9 awake rdata mode 000", reg_rdata, 32'h0000_000D);
      chk("R7 access granted", {31'b0, access_ok}, 32'd1);
   endtask

   task automatic t_sleep();
      wr(32'h0000_0004);
      repeat (3) tick();
      chk("R5 stays awake without request", {31'b0, clk_ready}, 32'd1);
      fw_sleep_req = 1'b1;
      for (int i = 0; i < int'(SLEEP); i++) begin
         tick();
         chk("R5 going to sleep", {31'b0, reg_rdata[4]}, 32'd1);
         chk("R7 access blocked while going to sleep", {31'b0, access_ok}, 32'd0);
      end
      tick();
      chk("R5 asleep rdata", reg_rdata, 32'h0100_0004);
   endtask

   task automatic t_rewake();
      repeat (12) tick();
      chk("R11 stays asleep while request held", {31'b0, clk_ready}, 32'd0);
      fw_sleep_req = 1'b0;
      repeat (WAKE) tick();
      chk("R11 not yet awake", {31'b0, clk_ready}, 32'd0);
      tick();
      chk("R11 awake again", {31'b0, clk_ready}, 32'd1);
   endtask

   task automatic t_cancel();
      fw_sleep_req = 1'b1;
      tick();
      chk("R5 sleep entry begun", {31'b0, reg_rdata[4]}, 32'd1);
      wr(32'h0000_000C);
      tick();
      chk("R6 sleep cancelled", {30'b0, reg_rdata[4], clk_ready}, 32'd1);
      repeat (10) tick();
      chk("R6 request ignored under wake hold", {30'b0, reg_rdata[4], clk_ready}, 32'd1);
      chk("R7 access kept", {31'b0, access_ok}, 32'd1);
      fw_sleep_req = 1'b0;
   endtask

   task automatic t_rfkill();
      rf_kill_in = 1'b1;
      repeat (SYNC - 1) tick();
      chk("R10 before sync delay", {31'b0, reg_rdata[27]}, 32'd0);
      tick();
      chk("R10 after sync delay", {31'b0, reg_rdata[27]}, 32'd1);
      chk("R9 radio-down mode", {29'b0, reg_rdata[26:24]}, 32'd2);
      rf_kill_in = 1'b0;
      repeat (SYNC) tick();
      chk("R10 released", {31'b0, reg_rdata[27]}, 32'd0);
      chk("R9 mode back to 000", {29'b0, reg_rdata[26:24]}, 32'd0);
   endtask

   task automatic t_init_clear();
      wr(32'h0000_0008);
      chk("R3 ready one cycle after clear", {31'b0, clk_ready}, 32'd1);
      tick();
      chk("R3 ready dropped", {30'b0, access_ok, clk_ready}, 32'd0);
      repeat (WAKE + 4) tick();
      chk("R3 stays down with wake hold", {31'b0, clk_ready}, 32'd0);
   endtask

   task automatic t_abort();
      wr(32'h0000_000C);
      repeat (3) tick();
      wr(32'h0000_0008);
      repeat (WAKE + 4) tick();
      chk("R11 aborted wake-up", {31'b0, clk_ready}, 32'd0);
   endtask

   task automatic t_softrst();
      wr(32'h0000_000C);
      repeat (WAKE + 1) tick();
      chk("R8 precondition awake", {31'b0, clk_ready}, 32'd1);
      @(negedge clk);
      soft_rst  = 1'b1;
      reg_wr_en = 1'b1;
      reg_wdata = 32'h0000_000C;
      @(negedge clk);
      soft_rst  = 1'b0;
      reg_wr_en = 1'b0;
      reg_wdata = '0;
      chk("R8 soft reset rdata", reg_rdata, 32'h0100_0000);
      chk("R8 soft reset pins", {30'b0, access_ok, clk_ready}, 32'd0);
      repeat (WAKE + 4) tick();
      chk("R8 stays low power", {31'b0, clk_ready}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_write_mask();
      t_wake();
      t_sleep();
      t_rewake();
      t_cancel();
      t_rfkill();
      t_init_clear();
      t_abort();
      t_softrst();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule